// File: doc/BRIEF.md
# Fixed Interval Timer Status Unit

This block turns a free-running time-base count into a periodic timer event. One of four time-base bit positions, chosen by a 2-bit select field, is watched for a 0-to-1 change. Each such change sets the fixed-interval status bit two clock edges later. A second status bit in the same register is set by a pulse from a neighbouring programmable-interval timer.

Software clears status bits by writing a mask: every 1 in the mask clears that bit and every 0 leaves it alone. The fixed-interval interrupt request is asserted while its status bit is set and both the timer's own enable and the global external-interrupt enable are high.

A write to the control register can move the select field onto a bit that is already high. That change must not count as an edge, so detection is masked in the cycle the write is presented.

Top module: `fitsu_top`

## Requirements
- R1: With the default parameters, select value 0, 1, 2 and 3 picks time-base bit 11, 15, 19 and 23 respectively. Bits at the other positions never set a status bit.
- R2: A 0-to-1 change of the selected bit, first seen at clock edge N, sets status bit 0 (fixed-interval) at edge N+1. The bit is still 0 after edge N and reads 1 after edge N+1.
- R3: A selected bit that stays high, or that falls from 1 to 0, sets nothing.
- R4: A status write with `stat_wr` high clears each bit whose mask bit is 1 and leaves each bit whose mask bit is 0 unchanged.
- R5: If a set event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R6: A `pit_set` pulse sets status bit 1 (programmable-interval) at the next edge. That bit obeys the same mask-clear rule.
- R7: `fit_irq` equals status bit 0 AND `fit_en` AND `ext_int_en`, with no clock delay. Status bit 1 does not drive it.
- R8: At an edge where `ctrl_wr` is high, no edge is detected, even if a select change makes the watched bit appear to rise. Detection resumes at the following edge.
- R9: While `rst_n` is low, the status register and `fit_irq` are 0. After release, a selected bit that is already high does not count as a rising edge.
- R10: A status bit with no set event and no clearing write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_value | input | TB_W | Free-running time-base count |
| ctrl_wr | input | 1 | High in the cycle a new control value is presented |
| fit_sel | input | 2 | Time-base bit select field |
| fit_en | input | 1 | Fixed-interval interrupt enable |
| ext_int_en | input | 1 | Global external-interrupt enable from machine state |
| pit_set | input | 1 | Set pulse for the programmable-interval status bit |
| stat_wr | input | 1 | Status register write strobe |
| stat_wmask | input | 2 | Clear mask: 1 clears the bit, 0 keeps it |
| status | output | 2 | Status register: bit 0 fixed-interval, bit 1 programmable-interval |
| fit_irq | output | 1 | Fixed-interval interrupt request |

## Verification
Each select value is tried with every other tap held high before its own tap rises. This shows that the mux picks the right bit and that the event lands exactly at the second edge rather than the first. Steady-high and falling patterns separate true edge detection from level sensing. A select change onto a high bit, first with the control-write mask and then with a clean rise, shows that the mask suppresses exactly one false event. Mask writes with all-zero, single-bit and coincident set patterns separate write-one-to-clear from direct data and confirm that a set wins over a clear.

// File: rtl/fitsu_pkg.sv
package fitsu_pkg;
  localparam int unsigned NTAP    = 4;
  localparam int unsigned SEL_W   = $clog2(NTAP);
  localparam int unsigned STAT_W  = 2;
  localparam int unsigned FIT_IDX = 0;
  localparam int unsigned PIT_IDX = 1;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/fitsu_rst_sync.sv
module fitsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fitsu_tap_sel.sv
module fitsu_tap_sel
  import fitsu_pkg::*;
#(
  parameter int unsigned TB_W = 32,
  parameter int unsigned TAP0 = 11,
  parameter int unsigned TAP1 = 15,
  parameter int unsigned TAP2 = 19,
  parameter int unsigned TAP3 = 23
) (
  input  logic [TB_W-1:0]  tb_value,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_bit
);
  localparam int unsigned TAP_POS [NTAP] = '{TAP0, TAP1, TAP2, TAP3};

  logic [NTAP-1:0] taps;
  logic            tb_unused;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign taps[g] = tb_value[TAP_POS[g]];
  end

  assign tb_unused = ^tb_value;
  assign tap_bit   = taps[sel];
endmodule

// File: rtl/fitsu_rise_det.sv
module fitsu_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_bit,
  input  logic ctrl_wr,
  output logic rise_q
);
  logic hist_q, hist_d;
  logic primed_q, primed_d;
  logic rise_d;

  always_comb begin
    hist_d   = tap_bit;
    primed_d = 1'b1;
    rise_d   = tap_bit & ~hist_q & primed_q & ~ctrl_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= 1'b0;
      primed_q <= 1'b0;
      rise_q   <= 1'b0;
    end else begin
      hist_q   <= hist_d;
      primed_q <= primed_d;
      rise_q   <= rise_d;
    end
  end

  AST_NO_RISE_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> !rise_q); // R9
  AST_CTRL_WR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !rise_q); // R8
  AST_RISE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> $past(tap_bit)); // R2
endmodule

// File: rtl/fitsu_stat_reg.sv
module fitsu_stat_reg
  import fitsu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_vec,
  input  logic  wr_en,
  input  stat_t wr_mask,
  output stat_t stat_q
);
  stat_t clr_vec;
  stat_t stat_d;

  always_comb begin
    clr_vec = wr_en ? wr_mask : '0;
    stat_d  = (stat_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> stat_q[i]); // R5
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mask[i] && !set_vec[i]) |=> !stat_q[i]); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_vec[i] && !(wr_en && wr_mask[i])) |=> stat_q[i] == $past(stat_q[i])); // R10
  end
endmodule

// File: rtl/fitsu_top.sv
module fitsu_top
  import fitsu_pkg::*;
#(
  parameter int unsigned TB_W = 32,
  parameter int unsigned TAP0 = 11,
  parameter int unsigned TAP1 = 15,
  parameter int unsigned TAP2 = 19,
  parameter int unsigned TAP3 = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TB_W-1:0]   tb_value,
  input  logic              ctrl_wr,
  input  logic [SEL_W-1:0]  fit_sel,
  input  logic              fit_en,
  input  logic              ext_int_en,
  input  logic              pit_set,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wmask,
  output logic [STAT_W-1:0] status,
  output logic              fit_irq
);
  logic  rst_n_int;
  logic  tap_bit;
  logic  fit_rise;
  stat_t set_vec;
  stat_t stat_q;

  fitsu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fitsu_tap_sel #(
    .TB_W (TB_W), .TAP0 (TAP0), .TAP1 (TAP1), .TAP2 (TAP2), .TAP3 (TAP3)
  ) u_tap (
    .tb_value (tb_value),
    .sel      (fit_sel),
    .tap_bit  (tap_bit)
  );

  fitsu_rise_det u_rise (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tap_bit (tap_bit),
    .ctrl_wr (ctrl_wr),
    .rise_q  (fit_rise)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FIT_IDX] = fit_rise;
    set_vec[PIT_IDX] = pit_set;
  end

  fitsu_stat_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .set_vec (set_vec),
    .wr_en   (stat_wr),
    .wr_mask (stat_wmask),
    .stat_q  (stat_q)
  );

  assign status  = stat_q;
  assign fit_irq = stat_q[FIT_IDX] & fit_en & ext_int_en;

  AST_FIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(stat_q[FIT_IDX]) |-> $past(tap_bit, 2)); // R2
endmodule

// File: tb/sim_fitsu_top.sv
module sim_fitsu_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS [4] = '{11, 15, 19, 23};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tb_value;
  logic        ctrl_wr;
  logic [1:0]  fit_sel;
  logic        fit_en;
  logic        ext_int_en;
  logic        pit_set;
  logic        stat_wr;
  logic [1:0]  stat_wmask;
  logic [1:0]  status;
  logic        fit_irq;

  int n_checks = 0;
  int n_err    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fitsu_top u0 (
    .clk (clk), .rst_n (rst_n), .tb_value (tb_value), .ctrl_wr (ctrl_wr),
    .fit_sel (fit_sel), .fit_en (fit_en), .ext_int_en (ext_int_en),
    .pit_set (pit_set), .stat_wr (stat_wr), .stat_wmask (stat_wmask),
    .status (status), .fit_irq (fit_irq)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    stat_wr = 1'b1; stat_wmask = 2'b11;
    tick();
    stat_wr = 1'b0; stat_wmask = 2'b00;
  endtask

  task automatic select(input int s);
    fit_sel = s[1:0]; ctrl_wr = 1'b1;
    tick();
    ctrl_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tb_value = '1; fit_en = 1'b1; ext_int_en = 1'b1;
    tick(2);
    chk("R9", "status in reset", status, 2'b00);
    chk("R9", "irq in reset", fit_irq, 1'b0);
    rst_n = 1'b1;
    tick(6);
    chk("R9", "high tap at release", status, 2'b00);
    tb_value = '0; fit_en = 1'b0; ext_int_en = 1'b0;
    tick(2);
  endtask

  task automatic t_tap_rise();
    for (int s = 0; s < 4; s++) begin
      logic [31:0] others;
      tb_value = '0;
      select(s);
      tick();
      clear_all();
      others = 32'h0000_0f0f;
      for (int k = 0; k < 4; k++) if (k != s) others[TAPS[k]] = 1'b1;
      others[TAPS[s]] = 1'b0;
      tb_value = others;
      tick(3);
      chk("R1", $sformatf("unselected taps sel=%0d", s), status, 2'b00);
      tb_value[TAPS[s]] = 1'b1;
      tick();
      chk("R2", $sformatf("after first edge sel=%0d", s), status, 2'b00);
      tick();
      chk("R2", $sformatf("after second edge sel=%0d", s), status, 2'b01);
      tb_value = '0;
      tick();
      clear_all();
    end
  endtask

  task automatic t_levels();
    tb_value = '0; select(0); tick(); clear_all();
    tb_value[TAPS[0]] = 1'b1;
    tick(4);
    clear_all();
    tick(4);
    chk("R3", "steady high", status, 2'b00);
    tb_value[TAPS[0]] = 1'b0;
    tick(4);
    chk("R3", "falling", status, 2'b00);
  endtask

  task automatic t_pit_w1c();
    clear_all();
    pit_set = 1'b1;
    tick();
    pit_set = 1'b0;
    chk("R6", "pit set", status, 2'b10);
    tb_value[TAPS[0]] = 1'b1;
    tick(2);
    chk("R2", "both set", status, 2'b11);
    tb_value = '0;
    stat_wr = 1'b1; stat_wmask = 2'b00;
    tick();
    stat_wr = 1'b0;
    chk("R4", "zero mask", status, 2'b11);
    tick(5);
    chk("R10", "hold", status, 2'b11);
    stat_wr = 1'b1; stat_wmask = 2'b10;
    tick();
    stat_wr = 1'b0;
    chk("R6", "clear pit only", status, 2'b01);
    stat_wr = 1'b1; stat_wmask = 2'b01;
    tick();
    stat_wr = 1'b0; stat_wmask = 2'b00;
    chk("R4", "clear fit", status, 2'b00);
  endtask

  task automatic t_set_wins();
    tb_value = '0; tick(2); clear_all();
    tb_value[TAPS[0]] = 1'b1;
    tick(2);
    tb_value = '0;
    tick(2);
    chk("R5", "precondition", status, 2'b01);
    tb_value[TAPS[0]] = 1'b1;
    tick();
    stat_wr = 1'b1; stat_wmask = 2'b11; pit_set = 1'b1;
    tick();
    stat_wr = 1'b0; stat_wmask = 2'b00; pit_set = 1'b0;
    chk("R5", "set beats clear", status, 2'b11);
    tb_value = '0;
    tick();
    clear_all();
  endtask

  task automatic t_irq();
    tb_value = '0; tick(); clear_all();
    pit_set = 1'b1; tick(); pit_set = 1'b0;
    fit_en = 1'b1; ext_int_en = 1'b1; #1;
    chk("R7", "pit bit only", fit_irq, 1'b0);
    tb_value[TAPS[0]] = 1'b1;
    tick(2);
    for (int c = 0; c < 4; c++) begin
      fit_en = c[0]; ext_int_en = c[1]; #1;
      chk("R7", $sformatf("enables %0d", c), fit_irq, (c == 3) ? 1 : 0);
    end
    stat_wr = 1'b1; stat_wmask = 2'b01;
    tick();
    stat_wr = 1'b0; stat_wmask = 2'b00; #1;
    chk("R7", "cleared status", fit_irq, 1'b0);
    fit_en = 1'b0; ext_int_en = 1'b0;
    tb_value = '0;
    clear_all();
  endtask

  task automatic t_ctrl_mask();
    tb_value = '0; select(0); tick(); clear_all();
    tb_value[TAPS[1]] = 1'b1;
    tick(3);
    chk("R8", "other tap high", status, 2'b00);
    select(1);
    tick(3);
    chk("R8", "select change ignored", status, 2'b00);
    tb_value[TAPS[1]] = 1'b0;
    tick(2);
    tb_value[TAPS[1]] = 1'b1;
    tick(2);
    chk("R8", "detection resumes", status, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; tb_value = '0; ctrl_wr = 1'b0; fit_sel = 2'd0;
    fit_en = 1'b0; ext_int_en = 1'b0; pit_set = 1'b0;
    stat_wr = 1'b0; stat_wmask = 2'b00;
    t_reset();
    t_tap_rise();
    t_levels();
    t_pit_w1c();
    t_set_wins();
    t_irq();
    t_ctrl_mask();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule